// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This block walks through the register indices of one short-vector floating-point operation. A `start_i` pulse loads an initial destination index, two source indices, a precision select, a vector length and a stride. The block then presents one index triple per clock on registered outputs, with `valid_o` set on every step and `last_o` set on the final one. A downstream register-file read/write stage uses each triple to issue one element of the operation.

The register file is split into banks. In single precision, index bits [4:3] name the bank and bits [2:0] the position within it. In double precision, bits [3:2] name the bank and bits [1:0] the position. The block decides what kind of operation it has from the banks of the operands. A destination in bank zero gives a scalar operation. A second source in bank zero gives a mixed operation, where that source stays fixed. Any other case gives a full vector operation. Every index advance wraps inside the bank the index started in. An external `force_scalar_i` input covers operations that are always scalar, such as the single-operand conversion and compare forms.

Top module: `vseq_index_gen`

## Requirements
- R1: After a synchronous reset, `valid_o`, `last_o` and `busy_o` are 0.
- R2: When `start_i` is accepted, the next cycle shows `rd_o`/`rn_o`/`rm_o` equal to the loaded `rd_i`/`rn_i`/`rm_i`, with `valid_o` = 1. `busy_o` stays 1 for exactly as long as `valid_o` is 1.
- R3: If `rd_i` lies in bank zero, the sequence has exactly one step, whatever `vlen_i` is. Bank zero means bits [4:3] = 0 in single precision and bits [3:2] = 0 in double precision.
- R4: Otherwise the sequence has `vlen_i` + 1 steps on consecutive cycles. `vlen_i` = 0 gives one step. `valid_o` drops in the cycle after the last step.
- R5: The destination step is `stride_i` + 1 in single precision (`dbl_i` = 0) and (`stride_i` >> 1) + 1 in double precision (`dbl_i` = 1).
- R6: If `rm_i` lies in bank zero, `rm_o` holds its initial value on every step (mixed mode). Otherwise `rm_o` advances by the destination step.
- R7: Each advance replaces an index r with its in-bank position field set to (r + step) mod bank size, keeping all other bits of r. Bank size is 8 in single precision and 4 in double precision. An index therefore never leaves its bank.
- R8: With `force_scalar_i` = 1 at start, the sequence has one step regardless of the banks and the length.
- R9: `last_o` is 1 on the final step only, and never while `valid_o` is 0.
- R10: A `start_i` that arrives while `busy_o` is 1 is ignored: the running sequence continues unchanged.
- R11: `rn_o` advances by the destination step on every step after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a sequence (accepted when not busy) |
| dbl_i | input | 1 | 1 selects double precision banking |
| force_scalar_i | input | 1 | Treat the operation as scalar |
| vlen_i | input | 3 | Vector length minus one |
| stride_i | input | 2 | Stride code |
| rd_i | input | 5 | Initial destination index |
| rn_i | input | 5 | Initial first source index |
| rm_i | input | 5 | Initial second source index |
| busy_o | output | 1 | Sequence in progress |
| valid_o | output | 1 | Index triple valid this cycle |
| last_o | output | 1 | Final triple of the sequence |
| rd_o | output | 5 | Current destination index |
| rn_o | output | 5 | Current first source index |
| rm_o | output | 5 | Current second source index |

## Verification
The bench aims at indices near the top of a bank with the largest strides, where a plain add without wrap would carry into the bank field and move the index into a neighbouring bank. It covers a destination in bank zero with the longest length, where a design that ignored the bank would emit eight steps instead of one. It covers a second source in bank zero, where a wrong design would advance that source. It covers double precision with odd stride codes, where halving the stride is easy to get wrong. Restarts issued during a running sequence would corrupt the triples or change the step count if the busy interlock were missing.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [1:0] {
    MODE_SCALAR = 2'd0,
    MODE_MIXED  = 2'd1,
    MODE_VECTOR = 2'd2
  } vseq_mode_e;

  localparam int LANE_RD = 0;
  localparam int LANE_RN = 1;
  localparam int LANE_RM = 2;
  localparam int LANES   = 3;
endpackage

// File: rtl/vseq_plan.sv
module vseq_plan #(
  parameter int IDX_W     = 5,
  parameter int VLEN_W    = 3,
  parameter int STRIDE_W  = 2,
  parameter int SGL_OFF_W = 3,
  parameter int DBL_OFF_W = 2,
  localparam int STEP_W   = STRIDE_W + 1
) (
  input  logic                   dbl,
  input  logic                   force_scalar,
  input  logic [VLEN_W-1:0]      vlen,
  input  logic [STRIDE_W-1:0]    stride,
  input  logic [IDX_W-1:0]       rd,
  input  logic [IDX_W-1:0]       rm,
  output vseq_pkg::vseq_mode_e   mode,
  output logic [VLEN_W-1:0]      count,
  output logic [STEP_W-1:0]      dstep,
  output logic [STEP_W-1:0]      mstep
);
  import vseq_pkg::*;

  localparam logic [IDX_W-1:0] BANK_S = IDX_W'(3 << SGL_OFF_W);
  localparam logic [IDX_W-1:0] BANK_D = IDX_W'(3 << DBL_OFF_W);

  logic [IDX_W-1:0] bank;
  logic             rd_zero;
  logic             rm_zero;

  always_comb begin
    bank    = dbl ? BANK_D : BANK_S;
    rd_zero = (rd & bank) == '0;
    rm_zero = (rm & bank) == '0;
    if (dbl) dstep = STEP_W'(stride >> 1) + STEP_W'(1);
    else     dstep = STEP_W'(stride) + STEP_W'(1);

    if (force_scalar || rd_zero) mode = MODE_SCALAR;
    else if (rm_zero)            mode = MODE_MIXED;
    else                         mode = MODE_VECTOR;

    count = (mode == MODE_SCALAR) ? '0 : vlen;
    mstep = (mode == MODE_VECTOR) ? dstep : '0;
  end
endmodule

// File: rtl/vseq_wrap.sv
module vseq_wrap #(
  parameter int IDX_W     = 5,
  parameter int STEP_W    = 3,
  parameter int SGL_OFF_W = 3,
  parameter int DBL_OFF_W = 2
) (
  input  logic              dbl,
  input  logic [IDX_W-1:0]  cur,
  input  logic [STEP_W-1:0] step,
  output logic [IDX_W-1:0]  nxt
);
  localparam logic [IDX_W-1:0] OFF_S = IDX_W'((1 << SGL_OFF_W) - 1);
  localparam logic [IDX_W-1:0] OFF_D = IDX_W'((1 << DBL_OFF_W) - 1);

  logic [IDX_W-1:0] off;
  logic [IDX_W-1:0] sum;

  always_comb begin
    off = dbl ? OFF_D : OFF_S;
    sum = cur + IDX_W'(step);
    nxt = (cur & ~off) | (sum & off);
  end
endmodule

// File: rtl/vseq_index_gen.sv
module vseq_index_gen #(
  parameter int IDX_W     = 5,
  parameter int VLEN_W    = 3,
  parameter int STRIDE_W  = 2,
  parameter int SGL_OFF_W = 3,
  parameter int DBL_OFF_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                dbl_i,
  input  logic                force_scalar_i,
  input  logic [VLEN_W-1:0]   vlen_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [IDX_W-1:0]    rd_i,
  input  logic [IDX_W-1:0]    rn_i,
  input  logic [IDX_W-1:0]    rm_i,
  output logic                busy_o,
  output logic                valid_o,
  output logic                last_o,
  output logic [IDX_W-1:0]    rd_o,
  output logic [IDX_W-1:0]    rn_o,
  output logic [IDX_W-1:0]    rm_o
);
  import vseq_pkg::*;

  localparam int STEP_W = STRIDE_W + 1;
  localparam logic [IDX_W-1:0] BANK_S = IDX_W'(3 << SGL_OFF_W);
  localparam logic [IDX_W-1:0] BANK_D = IDX_W'(3 << DBL_OFF_W);

  vseq_mode_e        plan_mode;
  logic [VLEN_W-1:0] plan_count;
  logic [STEP_W-1:0] plan_dstep;
  logic [STEP_W-1:0] plan_mstep;

  vseq_mode_e        mode_q;
  logic [VLEN_W-1:0] remain_q;
  logic [STEP_W-1:0] dstep_q;
  logic [STEP_W-1:0] mstep_q;
  logic              dbl_q;
  logic              valid_q;
  logic              last_q;
  logic [IDX_W-1:0]  cur_q     [LANES];
  logic [IDX_W-1:0]  nxt       [LANES];
  logic [IDX_W-1:0]  init_idx  [LANES];
  logic [STEP_W-1:0] lane_step [LANES];
  logic              accept;

  vseq_plan #(
    .IDX_W(IDX_W), .VLEN_W(VLEN_W), .STRIDE_W(STRIDE_W),
    .SGL_OFF_W(SGL_OFF_W), .DBL_OFF_W(DBL_OFF_W)
  ) u_plan (
    .dbl(dbl_i), .force_scalar(force_scalar_i), .vlen(vlen_i),
    .stride(stride_i), .rd(rd_i), .rm(rm_i),
    .mode(plan_mode), .count(plan_count),
    .dstep(plan_dstep), .mstep(plan_mstep)
  );

  assign init_idx[LANE_RD]  = rd_i;
  assign init_idx[LANE_RN]  = rn_i;
  assign init_idx[LANE_RM]  = rm_i;
  assign lane_step[LANE_RD] = dstep_q;
  assign lane_step[LANE_RN] = dstep_q;
  assign lane_step[LANE_RM] = mstep_q;

  assign accept = start_i && !valid_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vseq_wrap #(
      .IDX_W(IDX_W), .STEP_W(STEP_W),
      .SGL_OFF_W(SGL_OFF_W), .DBL_OFF_W(DBL_OFF_W)
    ) u_wrap (
      .dbl(dbl_q), .cur(cur_q[g]), .step(lane_step[g]), .nxt(nxt[g])
    );

    always_ff @(posedge clk) begin
      if (rst)                      cur_q[g] <= '0;
      else if (accept)              cur_q[g] <= init_idx[g];
      else if (valid_q && !last_q)  cur_q[g] <= nxt[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      last_q   <= 1'b0;
      remain_q <= '0;
      dstep_q  <= '0;
      mstep_q  <= '0;
      dbl_q    <= 1'b0;
      mode_q   <= MODE_SCALAR;
    end else if (accept) begin
      valid_q  <= 1'b1;
      last_q   <= (plan_count == '0);
      remain_q <= plan_count;
      dstep_q  <= plan_dstep;
      mstep_q  <= plan_mstep;
      dbl_q    <= dbl_i;
      mode_q   <= plan_mode;
    end else if (valid_q) begin
      if (last_q) begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
      end else begin
        remain_q <= remain_q - VLEN_W'(1);
        last_q   <= (remain_q == VLEN_W'(1));
      end
    end
  end

  assign busy_o  = valid_q;
  assign valid_o = valid_q;
  assign last_o  = last_q;
  assign rd_o    = cur_q[LANE_RD];
  assign rn_o    = cur_q[LANE_RN];
  assign rm_o    = cur_q[LANE_RM];

  logic [IDX_W-1:0] bank_q;
  assign bank_q = dbl_q ? BANK_D : BANK_S;

  // R9
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  // R10
  seq_continues_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o) |=> valid_o);

  // R3
  bank_zero_single_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && ((rd_i & (dbl_i ? BANK_D : BANK_S)) == '0)) |=> (valid_o && last_o));

  // R6
  mixed_rm_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && mode_q == MODE_MIXED) |=> $stable(rm_o));

  // R7
  rd_stays_in_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o) |=> ((rd_o & bank_q) == ($past(rd_o) & $past(bank_q))));
endmodule

// File: tb/vseq_index_gen_bench.sv
module vseq_index_gen_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       start_i, dbl_i, force_scalar_i;
  logic [2:0] vlen_i;
  logic [1:0] stride_i;
  logic [4:0] rd_i, rn_i, rm_i;
  logic       busy_o, valid_o, last_o;
  logic [4:0] rd_o, rn_o, rm_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  vseq_index_gen u_vseq_index_gen (
    .clk(clk), .rst(rst), .start_i(start_i), .dbl_i(dbl_i),
    .force_scalar_i(force_scalar_i), .vlen_i(vlen_i), .stride_i(stride_i),
    .rd_i(rd_i), .rn_i(rn_i), .rm_i(rm_i),
    .busy_o(busy_o), .valid_o(valid_o), .last_o(last_o),
    .rd_o(rd_o), .rn_o(rn_o), .rm_o(rm_o)
  );

  function automatic logic [4:0] adv(input logic [4:0] r, input int step, input logic dbl);
    logic [4:0] off;
    logic [4:0] s;
    off = dbl ? 5'h03 : 5'h07;
    s   = r + 5'(step);
    return (r & ~off) | (s & off);
  endfunction

  function automatic logic in_bank0(input logic [4:0] r, input logic dbl);
    return dbl ? (r[3:2] == 2'b00) : (r[4:3] == 2'b00);
  endfunction

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Runs one sequence; noisy=1 keeps start_i high with other values while busy.
  task automatic run_seq(input string tag, input logic dbl, input logic frc,
                         input logic [2:0] vl, input logic [1:0] st,
                         input logic [4:0] rd, input logic [4:0] rn,
                         input logic [4:0] rm, input bit noisy);
    int steps, dstep, mstep;
    logic [4:0] er, en, em;
    dstep = dbl ? (int'(st) >> 1) + 1 : int'(st) + 1;
    if (frc || in_bank0(rd, dbl)) begin
      steps = 1; mstep = 0;
    end else begin
      steps = int'(vl) + 1;
      mstep = in_bank0(rm, dbl) ? 0 : dstep;
    end
    er = rd; en = rn; em = rm;
    start_i = 1'b1; dbl_i = dbl; force_scalar_i = frc;
    vlen_i = vl; stride_i = st; rd_i = rd; rn_i = rn; rm_i = rm;
    @(posedge clk); @(negedge clk);
    for (int k = 0; k < steps; k++) begin
      check(tag, {busy_o, valid_o, last_o, rd_o, rn_o, rm_o},
            {1'b1, 1'b1, (k == steps - 1), er, en, em});
      if (noisy && k < steps - 1) begin
        start_i = 1'b1; dbl_i = ~dbl; force_scalar_i = 1'b1;
        vlen_i = ~vl; stride_i = ~st; rd_i = ~rd; rn_i = ~rn; rm_i = ~rm;
      end else begin
        start_i = 1'b0;
      end
      er = adv(er, dstep, dbl);
      en = adv(en, dstep, dbl);
      em = adv(em, mstep, dbl);
      @(posedge clk); @(negedge clk);
    end
    // R4 R9: sequence over one cycle after the final step
    check({tag, " end R4"}, {busy_o, valid_o, last_o, 14'd0}, 17'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; start_i = 1'b0; dbl_i = 1'b0; force_scalar_i = 1'b0;
    vlen_i = '0; stride_i = '0; rd_i = '0; rn_i = '0; rm_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    check("R1 reset", {busy_o, valid_o, last_o, 14'd0}, 17'd0);

    // R3: rd in bank zero, longest length
    run_seq("R3 bank0 single", 1'b0, 1'b0, 3'd7, 2'd1, 5'h05, 5'h09, 5'h11, 1'b0);
    run_seq("R3 bank0 double", 1'b1, 1'b0, 3'd7, 2'd0, 5'h02, 5'h06, 5'h0A, 1'b0);
    // R2 R4: length zero gives one step
    run_seq("R2 R4 len0", 1'b0, 1'b0, 3'd0, 2'd3, 5'h0A, 5'h12, 5'h1B, 1'b0);
    // R7 R11: single wrap 0x0E -> 0x08 -> 0x0A -> 0x0C
    run_seq("R7 R11 wrap single", 1'b0, 1'b0, 3'd3, 2'd1, 5'h0E, 5'h17, 5'h1F, 1'b0);
    // R5 R7: double, stride code 3 gives step 2
    run_seq("R5 R7 wrap double", 1'b1, 1'b0, 3'd3, 2'd3, 5'h07, 5'h0F, 5'h0B, 1'b0);
    // R5: double, stride code 1 gives step 1
    run_seq("R5 dbl stride1", 1'b1, 1'b0, 3'd4, 2'd1, 5'h06, 5'h0D, 5'h0E, 1'b0);
    // R6: rm in bank zero stays fixed
    run_seq("R6 mixed", 1'b0, 1'b0, 3'd5, 2'd2, 5'h19, 5'h0C, 5'h03, 1'b0);
    // R8: forced scalar
    run_seq("R8 forced", 1'b0, 1'b1, 3'd7, 2'd0, 5'h1C, 5'h14, 5'h0D, 1'b0);
    // R10: restarts while busy are ignored
    run_seq("R10 restart busy", 1'b0, 1'b0, 3'd7, 2'd0, 5'h08, 5'h10, 5'h18, 1'b1);

    for (int i = 0; i < 400; i++) begin
      logic       d, f;
      logic [4:0] a, b, c;
      d = 1'($urandom);
      f = ($urandom % 8) == 0;
      a = 5'($urandom); b = 5'($urandom); c = 5'($urandom);
      if (d) begin a[4] = 1'b0; b[4] = 1'b0; c[4] = 1'b0; end
      run_seq("R2 R4 R5 R6 R7 R9 R11 random", d, f, 3'($urandom), 2'($urandom),
              a, b, c, 1'(($urandom % 4) == 0));
      if (($urandom % 3) == 0) @(negedge clk);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule